// File: doc/BRIEF.md
# Selectively Gated Weight Summer

This block adds up to twenty-one unsigned weight words. Each word has its own enable bit, and a word counts toward the total only while its enable is high. There is no multiplier in the block. A term is its weight ANDed with the enable bit, zero-extended to the result width. The terms then go through one combinational reduction.

A register stage captures every weight and every enable on the rising clock edge. The total passes through a second register before it reaches the output. The only combinational logic is between these two register banks, so the reduction is one clean register-to-register path that timing analysis can time on its own.

The reduction comes in two forms, selected by a parameter:
- a balanced adder tree, which gives a short logic depth;
- a linear accumulate chain, which gives a compact layout.

Both forms give the same numbers. Elaboration-time checks reject any result width that could overflow for the chosen term count and weight width.

Top module: `gated_weight_summer`

## Requirements
- R1: `sum_o` equals the sum, over all 21 term positions k, of weight k multiplied by enable k.
- R2: Weight k is the unsigned 9-bit field `weights_i[9k+8:9k]`, and its enable is bit k of `selects_i`.
- R3: When every enable is 0, `sum_o` is 0 whatever the weight values are.
- R4: When only enable k is 1, `sum_o` equals weight k unchanged.
- R5: `sum_o` is 14 bits wide. With every weight at 511 and every enable at 1 it reads 10731, with no wrap.
- R6: Inputs present before rising edge n appear on `sum_o` after rising edge n+1. After edge n alone, `sum_o` still shows the earlier result.
- R7: A synchronous active-high `rst` clears the input registers and the output register. `sum_o` is 0 after the reset edge and after the edge that follows, whatever the inputs are.
- R8: The adder-tree form and the accumulate-chain form produce identical `sum_o` for identical input sequences.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for both register banks |
| rst | input | 1 | Synchronous active-high reset |
| weights_i | input | 189 | 21 packed unsigned 9-bit weights; term k occupies bits 9k+8:9k |
| selects_i | input | 21 | Per-term enable; bit k gates weight k |
| sum_o | output | 14 | Registered gated sum |

## Verification
A wrong bit in an input register shows on `sum_o` exactly two edges after the matching inputs were applied. The error is a difference of a power of two times the weight bit, or a whole weight, depending on which bit is wrong. A wrong bit in the output register shows one edge after it is captured, and only for that cycle, because the next edge reloads the register. A flaw in the reduction is persistent but depends on the data. That is why the checks use all-zero enables, full-scale weights, single enables that walk across each position, and random mixes. Comparing the tree form with the chain form on the same stimulus exposes any pairing or carry error in either form.

// File: rtl/gws_pkg.sv
package gws_pkg;

   typedef enum logic {
      RED_CHAIN = 1'b0,
      RED_TREE  = 1'b1
   } red_style_e;

   function automatic int unsigned ceil_log2(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((64'd1 << r) < 64'(v)) r++;
      return r;
   endfunction

   function automatic longint unsigned full_scale(input int unsigned n, input int unsigned w);
      return longint'(n) * ((longint'(1) << w) - 1);
   endfunction

endpackage

// File: rtl/gws_in_stage.sv
module gws_in_stage #(
   parameter int unsigned N_TERMS = 21,
   parameter int unsigned W_WIDTH = 9
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [N_TERMS*W_WIDTH-1:0]   weights_d,
   input  logic [N_TERMS-1:0]           selects_d,
   output logic [N_TERMS*W_WIDTH-1:0]   weights_q,
   output logic [N_TERMS-1:0]           selects_q
);
   for (genvar k = 0; k < N_TERMS; k++) begin : g_term_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            weights_q[k*W_WIDTH +: W_WIDTH] <= '0;
            selects_q[k]                    <= 1'b0;
         end else begin
            weights_q[k*W_WIDTH +: W_WIDTH] <= weights_d[k*W_WIDTH +: W_WIDTH];
            selects_q[k]                    <= selects_d[k];
         end
      end
   end
endmodule

// File: rtl/gws_term_gate.sv
module gws_term_gate #(
   parameter int unsigned N_TERMS = 21,
   parameter int unsigned W_WIDTH = 9,
   parameter int unsigned SUM_W   = 14
) (
   input  logic [N_TERMS*W_WIDTH-1:0] weights,
   input  logic [N_TERMS-1:0]         selects,
   output logic [N_TERMS*SUM_W-1:0]   terms
);
   localparam int unsigned PAD_W = SUM_W - W_WIDTH;

   for (genvar k = 0; k < N_TERMS; k++) begin : g_gate
      logic [W_WIDTH-1:0] gated;
      assign gated = weights[k*W_WIDTH +: W_WIDTH] & {W_WIDTH{selects[k]}};
      if (PAD_W == 0) begin : g_nopad
         assign terms[k*SUM_W +: SUM_W] = gated;
      end else begin : g_pad
         assign terms[k*SUM_W +: SUM_W] = {{PAD_W{1'b0}}, gated};
      end
   end
endmodule

// File: rtl/gws_reduce.sv
module gws_reduce
   import gws_pkg::*;
#(
   parameter int unsigned N_TERMS = 21,
   parameter int unsigned SUM_W   = 14,
   parameter red_style_e  STYLE   = RED_TREE
) (
   input  logic [N_TERMS*SUM_W-1:0] terms,
   output logic [SUM_W-1:0]         total
);
   localparam int unsigned LEVELS = ceil_log2(N_TERMS);
   localparam int unsigned LEAVES = 1 << LEVELS;
   localparam int unsigned NODES  = 2 * LEAVES - 1;
   localparam int unsigned FIRST  = LEAVES - 1;

   if (STYLE == RED_TREE) begin : g_tree
      // heap layout: node j sums children 2j+1 and 2j+2, leaves at FIRST..NODES-1
      logic [SUM_W-1:0] heap [NODES];
      for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
         if (i < N_TERMS) begin : g_used
            assign heap[FIRST+i] = terms[i*SUM_W +: SUM_W];
         end else begin : g_zero
            assign heap[FIRST+i] = '0;
         end
      end
      for (genvar j = 0; j < FIRST; j++) begin : g_add
         assign heap[j] = heap[2*j+1] + heap[2*j+2];
      end
      assign total = heap[0];
   end else begin : g_chain
      logic [SUM_W-1:0] acc [N_TERMS+1];
      assign acc[0] = '0;
      for (genvar k = 0; k < N_TERMS; k++) begin : g_step
         assign acc[k+1] = acc[k] + terms[k*SUM_W +: SUM_W];
      end
      assign total = acc[N_TERMS];
   end
endmodule

// File: rtl/gws_out_stage.sv
module gws_out_stage #(
   parameter int unsigned SUM_W = 14
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SUM_W-1:0] d,
   output logic [SUM_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end
endmodule

// File: rtl/gated_weight_summer.sv
module gated_weight_summer
   import gws_pkg::*;
#(
   parameter int unsigned N_TERMS   = 21,
   parameter int unsigned W_WIDTH   = 9,
   parameter int unsigned SUM_W     = 14,
   parameter red_style_e  RED_STYLE = RED_TREE
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [N_TERMS*W_WIDTH-1:0] weights_i,
   input  logic [N_TERMS-1:0]         selects_i,
   output logic [SUM_W-1:0]           sum_o
);
   localparam longint unsigned FULL  = full_scale(N_TERMS, W_WIDTH);
   localparam longint unsigned LIMIT = longint'(1) << SUM_W;

   if (N_TERMS < 1) begin : g_bad_terms
      $error("gated_weight_summer: N_TERMS must be at least 1");
   end
   if (W_WIDTH < 1 || W_WIDTH > SUM_W) begin : g_bad_width
      $error("gated_weight_summer: W_WIDTH must be 1..SUM_W");
   end
   if (SUM_W > 62 || FULL >= LIMIT) begin : g_bad_sum
      $error("gated_weight_summer: SUM_W too narrow for full-scale sum");
   end

   logic [N_TERMS*W_WIDTH-1:0] w_q;
   logic [N_TERMS-1:0]         s_q;
   logic [N_TERMS*SUM_W-1:0]   terms;
   logic [SUM_W-1:0]           total;

   gws_in_stage #(.N_TERMS(N_TERMS), .W_WIDTH(W_WIDTH)) u_in (
      .clk(clk), .rst(rst),
      .weights_d(weights_i), .selects_d(selects_i),
      .weights_q(w_q), .selects_q(s_q)
   );

   gws_term_gate #(.N_TERMS(N_TERMS), .W_WIDTH(W_WIDTH), .SUM_W(SUM_W)) u_gate (
      .weights(w_q), .selects(s_q), .terms(terms)
   );

   gws_reduce #(.N_TERMS(N_TERMS), .SUM_W(SUM_W), .STYLE(RED_STYLE)) u_red (
      .terms(terms), .total(total)
   );

   gws_out_stage #(.SUM_W(SUM_W)) u_out (
      .clk(clk), .rst(rst), .d(total), .q(sum_o)
   );
endmodule

// File: rtl/gws_checker.sv
module gws_checker #(
   parameter int unsigned N_TERMS = 21,
   parameter int unsigned W_WIDTH = 9,
   parameter int unsigned SUM_W   = 14
) (
   input logic                       clk,
   input logic                       rst,
   input logic [N_TERMS*W_WIDTH-1:0] weights_i,
   input logic [N_TERMS-1:0]         selects_i,
   input logic [SUM_W-1:0]           sum_o
);
   localparam logic [SUM_W-1:0] FULL_SUM = SUM_W'(N_TERMS * ((1 << W_WIDTH) - 1));

   logic [2:0] run_cnt;
   always_ff @(posedge clk) begin
      if (rst)               run_cnt <= '0;
      else if (run_cnt != 7) run_cnt <= run_cnt + 3'd1;
   end

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (run_cnt == 3'd1) |-> (sum_o == '0)); // R7

   AST_ZERO_SELECT: assert property (@(posedge clk) disable iff (rst)
      (run_cnt >= 3'd3 && $past(selects_i, 2) == '0) |-> (sum_o == '0)); // R3

   AST_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
      (run_cnt >= 3'd3 && $past(selects_i, 2) == '1 && $past(weights_i, 2) == '1)
      |-> (sum_o == FULL_SUM)); // R5

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (run_cnt >= 3'd3) |-> (sum_o <= FULL_SUM)); // R5

   AST_HOLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (run_cnt >= 3'd4 && $past(weights_i, 2) == $past(weights_i, 3)
       && $past(selects_i, 2) == $past(selects_i, 3)) |-> $stable(sum_o)); // R6
endmodule

bind gated_weight_summer gws_checker #(
   .N_TERMS(N_TERMS), .W_WIDTH(W_WIDTH), .SUM_W(SUM_W)
) u_chk (
   .clk(clk), .rst(rst), .weights_i(weights_i), .selects_i(selects_i), .sum_o(sum_o)
);

// File: tb/gated_weight_summer_bench.sv
`timescale 1ns/1ps
module gated_weight_summer_bench;
   localparam int N = 21;
   localparam int W = 9;
   localparam int S = 14;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [N*W-1:0] weights = '0;
   logic [N-1:0]   selects = '0;
   logic [S-1:0]   sum_tree, sum_chain;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   gated_weight_summer #(.N_TERMS(N), .W_WIDTH(W), .SUM_W(S),
      .RED_STYLE(gws_pkg::RED_TREE)) u_gated_weight_summer (
      .clk(clk), .rst(rst), .weights_i(weights), .selects_i(selects), .sum_o(sum_tree));

   gated_weight_summer #(.N_TERMS(N), .W_WIDTH(W), .SUM_W(S),
      .RED_STYLE(gws_pkg::RED_CHAIN)) u_chain (
      .clk(clk), .rst(rst), .weights_i(weights), .selects_i(selects), .sum_o(sum_chain));

   function automatic int ref_sum(input logic [N*W-1:0] w, input logic [N-1:0] s);
      int acc = 0;
      for (int k = 0; k < N; k++)
         if (s[k]) acc += int'(w[k*W +: W]);
      return acc;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_both(input string req, input int exp);
      chk(req, int'(sum_tree), exp);
      chk({req, "/R8"}, int'(sum_chain), int'(sum_tree));
   endtask

   // drive at negedge, sample at negedge two rising edges later
   task automatic apply_check(input string req, input logic [N*W-1:0] w, input logic [N-1:0] s);
      @(negedge clk);
      weights = w;
      selects = s;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk_both(req, ref_sum(w, s));
   endtask

   task automatic t_reset_state;
      @(negedge clk);
      chk_both("R7 reset state", 0);
   endtask

   task automatic t_all_zero_selects;
      logic [N*W-1:0] w;
      for (int k = 0; k < N; k++) w[k*W +: W] = W'($urandom_range(1, 511));
      apply_check("R3 zero selects", w, '0);
      apply_check("R3 zero selects max weights", '1, '0);
   endtask

   task automatic t_full_scale;
      apply_check("R5 full scale", '1, '1);
      chk("R5 value 10731", int'(sum_tree), 10731);
   endtask

   task automatic t_single_select;
      for (int k = 0; k < N; k++) begin
         logic [N*W-1:0] w;
         for (int j = 0; j < N; j++) w[j*W +: W] = W'((j * 37 + 5) % 512);
         w[k*W +: W] = W'(256 + k * 11);
         apply_check("R4 R2 single select", w, N'(1) << k);
      end
   endtask

   task automatic t_latency;
      logic [N*W-1:0] wa, wb;
      for (int k = 0; k < N; k++) begin
         wa[k*W +: W] = W'(k + 1);
         wb[k*W +: W] = W'(500 - k);
      end
      apply_check("R6 first value", wa, '1);
      @(negedge clk);
      weights = wb;
      @(posedge clk);
      @(negedge clk);
      chk_both("R6 old value after one edge", ref_sum(wa, '1));
      @(posedge clk);
      @(negedge clk);
      chk_both("R6 new value after two edges", ref_sum(wb, '1));
   endtask

   task automatic t_reset_clear;
      logic [N*W-1:0] w;
      for (int k = 0; k < N; k++) w[k*W +: W] = W'(300 + k);
      apply_check("R1 before reset", w, '1);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk_both("R7 after reset edge", 0);
      @(posedge clk);
      @(negedge clk);
      chk_both("R7 edge after reset", 0);
      @(posedge clk);
      @(negedge clk);
      chk_both("R7 recovery", ref_sum(w, '1));
   endtask

   task automatic t_random;
      for (int n = 0; n < 60; n++) begin
         logic [N*W-1:0] w;
         logic [N-1:0]   s;
         for (int k = 0; k < N; k++) w[k*W +: W] = W'($urandom_range(0, 511));
         s = N'($urandom);
         apply_check("R1 random", w, s);
      end
   endtask

   initial begin
      void'($urandom(32'h5a17));
      rst = 1'b1;
      repeat (3) @(posedge clk);
      t_reset_state();
      @(negedge clk);
      rst = 1'b0;
      t_all_zero_selects();
      t_full_scale();
      t_single_select();
      t_latency();
      t_reset_clear();
      t_random();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule